// File: doc/BRIEF.md
# Multi-Thread Stack Pointer Bank

This block holds the stack pointers of a barrel-threaded processor. Every hardware thread owns a fixed number of independent last-in-first-out stacks. A thread index input names the thread that is active in the current cycle, and it normally advances by one each clock. For that thread the block accepts push, pop and clear strobes and applies them to all of the thread's stacks in parallel. In the same cycle it returns one RAM address per stack, a write enable per stack, and a push-error and pop-error flag per stack. Pointer state for all threads lives in one array, and the update happens at the clock edge that ends the cycle.

Internally each stack keeps an occupancy level from 0 up to 2^PTR_W. The address for a push is the level itself, which is the next free slot. In every other case the address is the level minus one, which is the current top. Two parameters switch guarding on or off, one for pops and one for pushes. A guarded fault leaves the level unchanged. An unguarded fault wraps the level around: a pop from empty gives full, and a push to full gives empty.

Top module: `stack_ptr_bank`

## Requirements
- R1: Reset clears every level of every thread and stack to 0 (empty), so the first pop on any stack raises its pop error.
- R2: A push on stack s, with no pop on s and no clear, drives the address of s to the current level and raises wr_en_o[s]. The level then rises by one. Stack s occupies bits [s*PTR_W +: PTR_W] of ptr_o and bit s of each per-stack output.
- R3: A pop on stack s, with no push on s and no clear, drives the address of s to level-1 (the top) and lowers the level by one. A stack with no strobe also shows level-1, taken modulo 2^PTR_W.
- R4: A pop on an empty stack raises pop_err_o[s]. With POP_GUARD=1 the level stays at 0.
- R5: A push on a full stack (level 2^PTR_W) raises push_err_o[s] and shows address 0. With PUSH_GUARD=1 wr_en_o[s] stays low and the level stays full.
- R6: With a guard set to 0, the faulting operation wraps the level: a pop from empty gives full, and a push to full gives empty with wr_en_o[s] high.
- R7: A push and a pop on the same stack in the same cycle cancel each other: the level does not change, there is no error and no write enable, and the address is the top.
- R8: Each stack of the active thread is updated on its own, and several stacks may act in one cycle.
- R9: Only the stacks of the thread named by thread_id change. All other threads keep their levels.
- R10: clear empties every stack of the active thread. During the clear, push and pop are ignored, and no write enable or error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| thread_id | input | $clog2(THREADS) | Thread active this cycle |
| push | input | STACKS | Per-stack push strobe |
| pop | input | STACKS | Per-stack pop strobe |
| clear | input | 1 | Empty all stacks of the active thread |
| ptr_o | output | STACKS*PTR_W | Per-stack RAM address |
| wr_en_o | output | STACKS | Per-stack write enable for the data RAM |
| push_err_o | output | STACKS | Push onto a full stack |
| pop_err_o | output | STACKS | Pop from an empty stack |

## Verification
The bench fills one stack to exactly 2^PTR_W entries and pushes again. A design that tracked occupancy in PTR_W bits would see the stack as empty at that point and overwrite slot 0 without flagging an error. Separate checks target a push and a pop on the same stack in the same cycle, a clear that arrives together with strobes, and whether the levels of other threads survive a clear. A design that got these wrong would write, flag an error, or change another thread's level. A second instance with both guards off checks the wrap in each direction: a design that clamped instead of wrapping would keep reporting empty where the bench expects the level to have wrapped to full.

// File: rtl/stack_ptr_bank.sv
module stack_ptr_bank #(
  parameter int THREADS    = 8,
  parameter int STACKS     = 4,
  parameter int PTR_W      = 5,
  parameter int POP_GUARD  = 1,
  parameter int PUSH_GUARD = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [$clog2(THREADS)-1:0] thread_id,
  input  logic [STACKS-1:0]         push,
  input  logic [STACKS-1:0]         pop,
  input  logic                      clear,
  output logic [STACKS*PTR_W-1:0]   ptr_o,
  output logic [STACKS-1:0]         wr_en_o,
  output logic [STACKS-1:0]         push_err_o,
  output logic [STACKS-1:0]         pop_err_o
);
  localparam int SLOTS = THREADS * STACKS;
  localparam int IDX_W = $clog2(SLOTS);
  localparam int LVL_W = PTR_W + 1;
  localparam logic [LVL_W-1:0] DEPTH = LVL_W'(1) << PTR_W;

  logic [LVL_W-1:0] lvl [SLOTS];
  logic [LVL_W-1:0] cur [STACKS];
  logic [LVL_W-1:0] nxt [STACKS];
  logic [IDX_W-1:0] slot [STACKS];
  logic [IDX_W-1:0] base;

  assign base = IDX_W'(thread_id) * IDX_W'(STACKS);

  for (genvar s = 0; s < STACKS; s++) begin : g_stk
    logic empty, full, solo_push, solo_pop;
    assign slot[s]    = base + IDX_W'(s);
    assign cur[s]     = lvl[slot[s]];
    assign empty      = cur[s] == '0;
    assign full       = cur[s] == DEPTH;
    assign solo_push  = push[s] & ~pop[s] & ~clear;
    assign solo_pop   = pop[s] & ~push[s] & ~clear;

    assign push_err_o[s] = solo_push & full;
    assign pop_err_o[s]  = solo_pop & empty;
    assign wr_en_o[s]    = solo_push & ~((PUSH_GUARD != 0) & full);
    assign ptr_o[s*PTR_W +: PTR_W] = solo_push ? cur[s][PTR_W-1:0]
                                               : cur[s][PTR_W-1:0] - PTR_W'(1);

    always_comb begin
      nxt[s] = cur[s];
      if (clear)
        nxt[s] = '0;
      else if (solo_push)
        nxt[s] = full ? ((PUSH_GUARD != 0) ? cur[s] : '0) : cur[s] + LVL_W'(1);
      else if (solo_pop)
        nxt[s] = empty ? ((POP_GUARD != 0) ? cur[s] : DEPTH) : cur[s] - LVL_W'(1);
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) lvl[i] <= '0;
    end else begin
      for (int s = 0; s < STACKS; s++) lvl[slot[s]] <= nxt[s];
    end
  end
endmodule

// File: rtl/stack_ptr_bank_chk.sv
module stack_ptr_bank_chk #(
  parameter int THREADS    = 8,
  parameter int STACKS     = 4,
  parameter int PTR_W      = 5,
  parameter int POP_GUARD  = 1,
  parameter int PUSH_GUARD = 1,
  localparam int SLOTS = THREADS * STACKS,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int LVL_W = PTR_W + 1
) (
  input logic                       clk,
  input logic                       rst,
  input logic [$clog2(THREADS)-1:0] thread_id,
  input logic [STACKS-1:0]          push,
  input logic [STACKS-1:0]          pop,
  input logic                       clear,
  input logic [STACKS-1:0]          wr_en_o,
  input logic [STACKS-1:0]          push_err_o,
  input logic [STACKS-1:0]          pop_err_o,
  input logic [LVL_W-1:0]           lvl [SLOTS]
);
  localparam logic [LVL_W-1:0] DEPTH = LVL_W'(1) << PTR_W;
  logic [IDX_W-1:0] base_q;

  always_ff @(posedge clk or posedge rst)
    if (rst) base_q <= '0;
    else     base_q <= IDX_W'(thread_id) * IDX_W'(STACKS);

  for (genvar s = 0; s < STACKS; s++) begin : g_chk
    AST_WR_NEEDS_PUSH: assert property (@(posedge clk) disable iff (rst)
      wr_en_o[s] |-> push[s] && !pop[s] && !clear); // R2
    AST_POP_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
      pop_err_o[s] |-> pop[s] && !push[s]); // R4
    AST_PUSH_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
      push_err_o[s] |-> push[s] && !pop[s]); // R5
    AST_POP_GUARD_HOLD: assert property (@(posedge clk) disable iff (rst)
      (POP_GUARD != 0 && pop_err_o[s]) |=> lvl[base_q + IDX_W'(s)] == '0); // R4
    AST_PUSH_GUARD_HOLD: assert property (@(posedge clk) disable iff (rst)
      (PUSH_GUARD != 0 && push_err_o[s]) |=> lvl[base_q + IDX_W'(s)] == DEPTH && !$past(wr_en_o[s])); // R5
    AST_PAIR_QUIET: assert property (@(posedge clk) disable iff (rst)
      (push[s] && pop[s]) |-> !wr_en_o[s] && !push_err_o[s] && !pop_err_o[s]); // R7
    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (rst)
      clear |-> !wr_en_o[s] && !push_err_o[s] && !pop_err_o[s]); // R10
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
      clear |=> lvl[base_q + IDX_W'(s)] == '0); // R10
  end
endmodule

bind stack_ptr_bank stack_ptr_bank_chk #(
  .THREADS(THREADS), .STACKS(STACKS), .PTR_W(PTR_W),
  .POP_GUARD(POP_GUARD), .PUSH_GUARD(PUSH_GUARD)
) chk (
  .clk(clk), .rst(rst), .thread_id(thread_id), .push(push), .pop(pop),
  .clear(clear), .wr_en_o(wr_en_o), .push_err_o(push_err_o),
  .pop_err_o(pop_err_o), .lvl(lvl)
);

// File: tb/stack_ptr_bank_test.sv
module stack_ptr_bank_test;
  logic clk = 0, rst = 1;
  always #10 clk = ~clk;

  logic [2:0] thr, r_thr;
  logic [3:0] psh, pp, r_psh, r_pp;
  logic clr, r_clr;
  logic [19:0] ptr, r_ptr;
  logic [3:0] wr, perr_push, perr_pop, r_wr, r_perr_push, r_perr_pop;
  int checks = 0, fails = 0;
  bit done = 0;

  stack_ptr_bank uut (.clk(clk), .rst(rst), .thread_id(thr), .push(psh), .pop(pp),
    .clear(clr), .ptr_o(ptr), .wr_en_o(wr), .push_err_o(perr_push), .pop_err_o(perr_pop));

  stack_ptr_bank #(.POP_GUARD(0), .PUSH_GUARD(0)) uut_raw (.clk(clk), .rst(rst),
    .thread_id(r_thr), .push(r_psh), .pop(r_pp), .clear(r_clr), .ptr_o(r_ptr),
    .wr_en_o(r_wr), .push_err_o(r_perr_push), .pop_err_o(r_perr_pop));

  typedef struct packed {
    logic [2:0] thr; logic [3:0] psh; logic [3:0] pp; logic clr;
    logic [19:0] ptr; logic [3:0] wr; logic [3:0] epush; logic [3:0] epop;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 4'b0001, 4'b0000, 1'b0, {5'd31,5'd31,5'd31,5'd0},  4'b0001, 4'b0000, 4'b0000},
    '{3'd2, 4'b1111, 4'b0000, 1'b0, {5'd0, 5'd0, 5'd0, 5'd0},  4'b1111, 4'b0000, 4'b0000},
    '{3'd1, 4'b0011, 4'b0000, 1'b0, {5'd31,5'd31,5'd0, 5'd1},  4'b0011, 4'b0000, 4'b0000},
    '{3'd1, 4'b0000, 4'b0001, 1'b0, {5'd31,5'd31,5'd0, 5'd1},  4'b0000, 4'b0000, 4'b0000},
    '{3'd1, 4'b0000, 4'b0100, 1'b0, {5'd31,5'd31,5'd0, 5'd0},  4'b0000, 4'b0000, 4'b0100},
    '{3'd1, 4'b0001, 4'b0001, 1'b0, {5'd31,5'd31,5'd0, 5'd0},  4'b0000, 4'b0000, 4'b0000},
    '{3'd1, 4'b1000, 4'b1000, 1'b0, {5'd31,5'd31,5'd0, 5'd0},  4'b0000, 4'b0000, 4'b0000},
    '{3'd2, 4'b0000, 4'b0110, 1'b0, {5'd0, 5'd0, 5'd0, 5'd0},  4'b0000, 4'b0000, 4'b0000},
    '{3'd2, 4'b1111, 4'b0000, 1'b1, {5'd0, 5'd31,5'd31,5'd0},  4'b0000, 4'b0000, 4'b0000},
    '{3'd2, 4'b0000, 4'b1111, 1'b0, {5'd31,5'd31,5'd31,5'd31}, 4'b0000, 4'b0000, 4'b1111},
    '{3'd1, 4'b0000, 4'b0000, 1'b0, {5'd31,5'd31,5'd0, 5'd0},  4'b0000, 4'b0000, 4'b0000},
    '{3'd0, 4'b0000, 4'b0000, 1'b0, {5'd31,5'd31,5'd31,5'd31}, 4'b0000, 4'b0000, 4'b0000}
  };
  localparam string TAGS [NV] = '{"R2 R8", "R2 R8 R9", "R2 R8", "R3", "R4", "R7",
    "R7", "R3 R8", "R10", "R10 R4", "R9 R10", "R1 R9"};

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic [2:0] t, logic [3:0] pu, logic [3:0] po, logic c);
    @(negedge clk);
    thr = t; psh = pu; pp = po; clr = c;
    #5;
  endtask

  task automatic rstep(logic [3:0] pu, logic [3:0] po);
    @(negedge clk);
    r_thr = 3'd0; r_psh = pu; r_pp = po; r_clr = 1'b0;
    #5;
  endtask

  initial begin
    thr = 0; psh = 0; pp = 0; clr = 0;
    r_thr = 0; r_psh = 0; r_pp = 0; r_clr = 0;
    repeat (2) @(negedge clk);
    rst = 0;

    for (int t = 0; t < 8; t++) begin
      step(3'(t), 4'b0000, 4'b1111, 1'b0);
      check("R1 reset empty", {60'd0, perr_pop}, {60'd0, 4'b1111});
    end

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].thr, VECS[i].psh, VECS[i].pp, VECS[i].clr);
      check(TAGS[i], {28'd0, ptr, wr, perr_push, perr_pop},
            {28'd0, VECS[i].ptr, VECS[i].wr, VECS[i].epush, VECS[i].epop});
    end

    for (int i = 0; i < 32; i++) begin
      step(3'd5, 4'b1000, 4'b0000, 1'b0);
      check("R2 fill", {58'd0, ptr[19:15], wr[3]}, {58'd0, 5'(i), 1'b1});
    end
    step(3'd5, 4'b1000, 4'b0000, 1'b0);
    check("R5 push full", {56'd0, ptr[19:15], wr[3], perr_push[3], 1'b0},
          {56'd0, 5'd0, 1'b0, 1'b1, 1'b0});
    step(3'd5, 4'b1000, 4'b0000, 1'b0);
    check("R5 guard holds full", {62'd0, wr[3], perr_push[3]}, {62'd0, 1'b0, 1'b1});
    step(3'd5, 4'b0000, 4'b1000, 1'b0);
    check("R3 pop from full", {58'd0, ptr[19:15], perr_pop[3]}, {58'd0, 5'd31, 1'b0});
    step(3'd5, 4'b0000, 4'b1000, 1'b0);
    check("R3 pop top", {59'd0, ptr[19:15]}, {59'd0, 5'd30});
    step(3'd5, 4'b0000, 4'b0000, 1'b0);
    check("R9 other stacks of thread 5", {44'd0, ptr[14:0], perr_pop},
          {44'd0, {5'd31, 5'd31, 5'd31}, 4'b0000});

    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    step(3'd5, 4'b0000, 4'b1000, 1'b0);
    check("R1 reset mid-run", {63'd0, perr_pop[3]}, {63'd0, 1'b1});

    rstep(4'b0000, 4'b0001);
    check("R6 raw pop empty", {62'd0, r_perr_pop[0], r_wr[0]}, {62'd0, 1'b1, 1'b0});
    rstep(4'b0001, 4'b0000);
    check("R6 raw wrapped to full", {57'd0, r_ptr[4:0], r_wr[0], r_perr_push[0]},
          {57'd0, 5'd0, 1'b1, 1'b1});
    rstep(4'b0000, 4'b0001);
    check("R6 raw wrapped to empty", {63'd0, r_perr_pop[0]}, {63'd0, 1'b1});
    rstep(4'b0001, 4'b0000);
    check("R6 raw push after wrap", {57'd0, r_ptr[4:0], r_wr[0], r_perr_push[0]},
          {57'd0, 5'd0, 1'b1, 1'b1});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule